// File: doc/BRIEF.md
# Exception Entry Sequencer

This block switches processor state when one of three exception sources is signalled: an external interrupt request, a software-interrupt instruction, or an instruction the decoder does not recognise. Each cycle it samples the core's current status word, program counter, instruction-width flag and the three request lines. When a request is taken, the block computes the new operating mode for the banked register file and the return (link) value. It also computes the new program counter, the status word to be saved in the new mode, and the status word the core should adopt. One cycle later it presents all of these values with a single-cycle redirect strobe, which the fetch unit uses to flush and refill.

Interrupt requests are dropped silently while the status word's interrupt-disable bit is set. The two synchronous sources are never masked. The results are registered and stay on the outputs until the next strobe. The core copies them into its register file on the strobe cycle. Every pin is plain control or status: the core holds no handshake with this block. A request that arrives during the strobe cycle is ignored, because the core is still loading the previous entry's state.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset every output is zero and no strobe is raised until a request is taken.
- R2: An interrupt request is ignored while bit 7 (interrupt disable) of `in_sr` is 1. When it is the only request, no strobe follows and every output keeps its previous value.
- R3: For a taken interrupt request, `out_link` = `in_pc` − W + 4. W is 2 when `in_narrow` is 1 and 4 when it is 0.
- R4: For a taken software interrupt or undefined instruction, `out_link` = `in_pc` − W, with W defined as in R3.
- R5: `out_mode` is 5'h12 for an interrupt request, 5'h13 for a software interrupt and 5'h1B for an undefined instruction.
- R6: `out_saved_sr` equals the `in_sr` sampled with the request. `out_new_sr` equals that word with bits [4:0] replaced by the R5 mode, bit 7 set to 1 and bit 5 (narrow-state flag) cleared to 0.
- R7: `out_pc` is 32'h04 for undefined, 32'h08 for software interrupt and 32'h18 for interrupt request.
- R8: When several requests are present together, undefined wins over software interrupt, and both win over interrupt request.
- R9: `out_redirect` is high for exactly the one cycle after the edge that sampled a taken request. Requests present in that strobe cycle are ignored.
- R10: `out_wake` pulses together with `out_redirect` only when the taken exception is an interrupt request. It stays 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sr | input | 32 | Current status word (bit 7 interrupt disable, bit 5 narrow state, [4:0] mode) |
| in_pc | input | 32 | Current program counter value |
| in_narrow | input | 1 | 1 when the core executes 16-bit instructions |
| req_und | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_irq | input | 1 | Interrupt request (level) |
| out_redirect | output | 1 | One-cycle strobe: new state is valid, fetch must flush |
| out_mode | output | 5 | Target mode for the banked register file |
| out_link | output | 32 | Return value for the new mode's link register |
| out_pc | output | 32 | Vector address to fetch from |
| out_saved_sr | output | 32 | Status word to store as the new mode's saved status |
| out_new_sr | output | 32 | Status word the core adopts |
| out_wake | output | 1 | Clears the core's halted state (interrupt entry only) |

## Verification
Random status words, program counters, width flags and request combinations are driven, and each result is compared with a reference computed in the bench. Directed cases cover every source in both instruction widths, which separates the +4 interrupt adjustment from the synchronous one and the 2-byte step from the 4-byte step. They also cover an interrupt with the disable bit both set and clear, which shows silent dropping against entry. All three requests together and two-request pairs check the priority order. Back-to-back requests check that the strobe-cycle lockout holds and that outputs are kept while no exception is taken.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int SR_W      = 32;
  localparam int MODE_W    = 5;
  localparam int SR_IDIS   = 7;
  localparam int SR_NARROW = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_UND = 5'h1B
  } exc_mode_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_UND  = 2'd1,
    KIND_SWI  = 2'd2,
    KIND_IRQ  = 2'd3
  } exc_kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_und,
  input  logic      req_swi,
  input  logic      req_irq,
  input  logic      irq_masked,
  input  logic      lockout,
  output logic      take,
  output exc_kind_e kind
);
  logic [2:0] grant; // [0] und, [1] swi, [2] irq

  always_comb begin
    grant = 3'b000;
    if (!lockout) begin
      if (req_und)                  grant[0] = 1'b1;
      else if (req_swi)             grant[1] = 1'b1;
      else if (req_irq && !irq_masked) grant[2] = 1'b1;
    end
  end

  always_comb begin
    unique case (grant)
      3'b001:  kind = KIND_UND;
      3'b010:  kind = KIND_SWI;
      3'b100:  kind = KIND_IRQ;
      default: kind = KIND_NONE;
    endcase
  end

  assign take = |grant;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8
  AST_MASKED_IRQ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_masked && !req_und && !req_swi) |-> !take); // R2
  AST_SYNC_BEATS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (req_und || req_swi)) |-> (kind != KIND_IRQ)); // R8
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
  import exc_entry_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          WIDE_STEP = 4,
  parameter int          NARROW_STEP = 2,
  parameter logic [31:0] VEC_UND   = 32'h04,
  parameter logic [31:0] VEC_SWI   = 32'h08,
  parameter logic [31:0] VEC_IRQ   = 32'h18
) (
  input  exc_kind_e             kind,
  input  logic [ADDR_W-1:0]     pc,
  input  logic                  narrow,
  output logic [ADDR_W-1:0]     link,
  output logic [ADDR_W-1:0]     vector,
  output logic [MODE_W-1:0]     mode
);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(WIDE_STEP);
  localparam logic [ADDR_W-1:0] STEP_N = ADDR_W'(NARROW_STEP);
  localparam logic [ADDR_W-1:0] IRQ_ADJ = ADDR_W'(WIDE_STEP);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] base_ret;

  assign step     = narrow ? STEP_N : STEP_W;
  assign base_ret = pc - step;

  always_comb begin
    link   = base_ret;
    vector = ADDR_W'(VEC_UND);
    mode   = MODE_UND;
    case (kind)
      KIND_SWI: begin
        vector = ADDR_W'(VEC_SWI);
        mode   = MODE_SVC;
      end
      KIND_IRQ: begin
        link   = base_ret + IRQ_ADJ;
        vector = ADDR_W'(VEC_IRQ);
        mode   = MODE_IRQ;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_status_update.sv
module exc_status_update
  import exc_entry_pkg::*;
(
  input  logic [SR_W-1:0]   sr_in,
  input  logic [MODE_W-1:0] mode,
  output logic [SR_W-1:0]   sr_out
);
  always_comb begin
    for (int b = 0; b < SR_W; b++) begin
      if (b < MODE_W)            sr_out[b] = mode[b];
      else if (b == SR_IDIS)     sr_out[b] = 1'b1;
      else if (b == SR_NARROW)   sr_out[b] = 1'b0;
      else                       sr_out[b] = sr_in[b];
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       in_sr,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic              in_narrow,
  input  logic              req_und,
  input  logic              req_swi,
  input  logic              req_irq,
  output logic              out_redirect,
  output logic [4:0]        out_mode,
  output logic [ADDR_W-1:0] out_link,
  output logic [ADDR_W-1:0] out_pc,
  output logic [31:0]       out_saved_sr,
  output logic [31:0]       out_new_sr,
  output logic              out_wake
);
  logic              take;
  exc_kind_e         kind;
  logic [ADDR_W-1:0] nx_link, nx_vec;
  logic [MODE_W-1:0] nx_mode;
  logic [SR_W-1:0]   nx_sr;

  exc_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_und   (req_und),
    .req_swi   (req_swi),
    .req_irq   (req_irq),
    .irq_masked(in_sr[SR_IDIS]),
    .lockout   (out_redirect),
    .take      (take),
    .kind      (kind)
  );

  exc_target_calc #(.ADDR_W(ADDR_W)) u_calc (
    .kind  (kind),
    .pc    (in_pc),
    .narrow(in_narrow),
    .link  (nx_link),
    .vector(nx_vec),
    .mode  (nx_mode)
  );

  exc_status_update u_sr (
    .sr_in (in_sr),
    .mode  (nx_mode),
    .sr_out(nx_sr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_redirect <= 1'b0;
      out_wake     <= 1'b0;
      out_mode     <= '0;
      out_link     <= '0;
      out_pc       <= '0;
      out_saved_sr <= '0;
      out_new_sr   <= '0;
    end else begin
      out_redirect <= take;
      out_wake     <= take && (kind == KIND_IRQ);
      if (take) begin
        out_mode     <= nx_mode;
        out_link     <= nx_link;
        out_pc       <= nx_vec;
        out_saved_sr <= in_sr;
        out_new_sr   <= nx_sr;
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_redirect |=> !out_redirect); // R9
  AST_WAKE_ONLY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_wake |-> (out_redirect && out_mode == MODE_IRQ)); // R10
  AST_NEW_SR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_redirect |-> (out_new_sr[SR_IDIS] && !out_new_sr[SR_NARROW])); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_redirect && $past(rst_n)) |-> $stable(out_link)); // R2
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] in_sr, in_pc;
  logic        in_narrow, req_und, req_swi, req_irq;
  logic        out_redirect, out_wake;
  logic [4:0]  out_mode;
  logic [31:0] out_link, out_pc, out_saved_sr, out_new_sr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        e_red, e_wake;
  logic [4:0]  e_mode;
  logic [31:0] e_link, e_pc, e_ssr, e_nsr;

  always #5 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .in_sr(in_sr), .in_pc(in_pc), .in_narrow(in_narrow),
    .req_und(req_und), .req_swi(req_swi), .req_irq(req_irq),
    .out_redirect(out_redirect), .out_mode(out_mode), .out_link(out_link),
    .out_pc(out_pc), .out_saved_sr(out_saved_sr), .out_new_sr(out_new_sr),
    .out_wake(out_wake)
  );

  // 0 none, 1 und, 2 swi, 3 irq
  function automatic int pick(logic u, logic s, logic i, logic [31:0] sr, logic lock);
    if (lock) return 0;
    if (u) return 1;
    if (s) return 2;
    if (i && !sr[7]) return 3;
    return 0;
  endfunction

  function automatic logic [4:0] mode_of(int k);
    return (k == 3) ? 5'h12 : (k == 2) ? 5'h13 : 5'h1B;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " R9 redirect"}, {31'b0, out_redirect}, {31'b0, e_red});
    chk({tag, " R10 wake"}, {31'b0, out_wake}, {31'b0, e_wake});
    chk({tag, " R5 mode"}, {27'b0, out_mode}, {27'b0, e_mode});
    chk({tag, " R3/R4 link"}, out_link, e_link);
    chk({tag, " R7 vector"}, out_pc, e_pc);
    chk({tag, " R6 saved"}, out_saved_sr, e_ssr);
    chk({tag, " R6 new"}, out_new_sr, e_nsr);
  endtask

  task automatic step(logic [31:0] sr, logic [31:0] pc, logic nar,
                      logic u, logic s, logic i, string tag);
    int k;
    @(negedge clk);
    in_sr = sr; in_pc = pc; in_narrow = nar;
    req_und = u; req_swi = s; req_irq = i;
    k = pick(u, s, i, sr, e_red);
    e_red  = (k != 0);
    e_wake = (k == 3);
    if (k != 0) begin
      e_mode = mode_of(k);
      e_link = pc - (nar ? 32'd2 : 32'd4) + ((k == 3) ? 32'd4 : 32'd0);
      e_pc   = (k == 1) ? 32'h04 : (k == 2) ? 32'h08 : 32'h18;
      e_ssr  = sr;
      e_nsr  = {sr[31:8], 1'b1, sr[6], 1'b0, mode_of(k)};
    end
    @(posedge clk); #2;
    compare(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 0; in_sr = 0; in_pc = 0; in_narrow = 0;
    req_und = 0; req_swi = 0; req_irq = 0;
    e_red = 0; e_wake = 0; e_mode = 0; e_link = 0; e_pc = 0; e_ssr = 0; e_nsr = 0;
    repeat (3) @(posedge clk);
    #2 compare("R1 reset");
    @(negedge clk); rst_n = 1;
    step(32'h0000_001F, 32'h100, 0, 0, 0, 0, "R1 idle");
    // R3 irq both widths
    step(32'h6000_003F, 32'h1000, 0, 0, 0, 1, "R3 irq wide");
    step(32'h0, 32'h0, 0, 0, 0, 0, "R9 gap");
    step(32'h0000_0030, 32'h2002, 1, 0, 0, 1, "R3 irq narrow");
    step(32'h0, 32'h0, 0, 0, 0, 0, "R9 gap");
    // R2 masked irq
    step(32'hF000_00BF, 32'h3000, 0, 0, 0, 1, "R2 masked");
    step(32'h0000_0080, 32'h3004, 1, 0, 0, 1, "R2 masked again");
    // R4 swi/und both widths
    step(32'h0000_009F, 32'h4000, 0, 0, 1, 0, "R4 swi wide");
    step(32'h0, 32'h0, 0, 0, 0, 0, "R9 gap");
    step(32'h0000_00BF, 32'h5002, 1, 1, 0, 0, "R4 und narrow");
    step(32'h0, 32'h0, 0, 0, 0, 0, "R9 gap");
    // R8 priority
    step(32'h0000_001F, 32'h6000, 0, 1, 1, 1, "R8 all three");
    step(32'h0000_001F, 32'h6100, 0, 0, 1, 1, "R9 lockout");
    step(32'h0000_001F, 32'h6200, 0, 0, 1, 1, "R8 swi over irq");
    step(32'h0, 32'h0, 0, 0, 0, 0, "R9 gap");
    step(32'h0000_001F, 32'h6300, 1, 1, 1, 0, "R8 und over swi");
    step(32'h0, 32'h0, 0, 0, 0, 0, "R9 gap");
    step(32'h0000_0000, 32'h0000_0002, 1, 0, 1, 0, "R4 wrap");
    for (int n = 0; n < 400; n++) begin
      logic [2:0] r;
      r = 3'($urandom());
      step($urandom(), $urandom(), 1'($urandom()), r[0] & r[1], r[1] & ~r[0], r[2],
           "rand R2-R10");
    end
    finish_run();
  end
endmodule